// File: doc/BRIEF.md
# ADC Burst Conversion Sequencer

This block sequences a successive-approximation converter that runs on its own fast clock, independent of a slow or halted system clock. A single start request wakes the converter. If the converter is powered down, the block first waits a programmable power-up interval. It then runs a chosen number of track-and-convert passes and sums the 10-bit samples into a 16-bit accumulator. When the last pass finishes, it publishes the total, raises an end-of-conversion flag and records whether the total lies inside a programmable window.

There are two modes. In burst mode one start runs every pass of the sequence back to back. In single mode each start runs exactly one pass, and the flag appears only after the start that completes the count. After each run an idle policy input decides whether the converter is switched off or left powered. The start input is assumed to be already synchronous to the converter clock.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset `result` is 0, and `eoc_flag`, `win_hit`, `overrun`, `conv_on` and `busy` are all low.
- R2: The repeat count comes from `rpt_sel`: codes 1 to 5 select 4, 8, 16, 32 and 64 passes; code 0 selects 1 pass. With `burst_en` high, one start runs all passes and `result` equals the sum of the samples taken.
- R3: With `burst_en` low, each start runs one pass. `eoc_flag` stays low until the start that completes the count, and `result` is the sum over all starts of that sequence.
- R4: `eoc_flag` rises K cycles after the clock edge that accepts the start of the final run. K = P + N*(T + 11). P is `pwr_time`+1 if `conv_on` was low at that start, and 0 otherwise. T is `trk_time` + 3*`extra_track` + 1. N is the number of passes in that run.
- R5: At the end of every run `conv_on` takes the value of `stay_on`. A start while `conv_on` is high skips the power-up wait.
- R6: With `extra_track` high, every pass gets 3 more tracking cycles, as counted in R4.
- R7: `win_hit` is set together with `eoc_flag` only if `win_lo` <= final sum <= `win_hi`. Partial sums are never compared.
- R8: A start while `busy` is high is ignored. It leaves the running sequence, its result and its timing unchanged, and it sets the sticky `overrun` bit.
- R9: A one-cycle `flag_clr` pulse clears `eoc_flag`, `win_hit` and `overrun` and leaves `result` unchanged.
- R10: The accumulator clears when a new sequence starts, so each result depends only on the samples of its own sequence.
- R11: Unused `rpt_sel` codes 6 and 7 select a single pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter (burst) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Convert-start pulse, one cycle |
| burst_en | input | 1 | 1: one start runs all passes; 0: one pass per start |
| stay_on | input | 1 | Idle policy: 1 keeps the converter powered between runs |
| extra_track | input | 1 | Adds 3 tracking cycles before each pass |
| pwr_time | input | 8 | Power-up wait, in cycles minus one |
| trk_time | input | 4 | Tracking time, in cycles minus one |
| rpt_sel | input | 3 | Repeat count code |
| sample_in | input | 10 | Sample from the analog front end |
| win_lo | input | 16 | Lower window bound (inclusive) |
| win_hi | input | 16 | Upper window bound (inclusive) |
| flag_clr | input | 1 | Clears the status flags |
| result | output | 16 | Accumulated result of the last completed sequence |
| eoc_flag | output | 1 | End of conversion, sticky |
| win_hit | output | 1 | Final sum was inside the window, sticky |
| overrun | output | 1 | Start arrived while busy, sticky |
| conv_on | output | 1 | Converter power enable |
| busy | output | 1 | A power-up, tracking or conversion is in progress |

## Verification
Every completion is due exactly K cycles after the edge that accepted the final start, as defined in R4. The driver computes K from the power state it expects, the repeat count and the tracking settings. It stores that due cycle with the expected sum and window outcome. The monitor compares `result` and `win_hit` at the first falling edge where `eoc_flag` is high, and it requires that edge to fall on the due cycle, so both early and late completions are reported. Power state and flag clearing are sampled on the falling edge after the edge that should have changed them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RPT_W  = 7;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PWRUP = 2'd1,
    ST_TRACK = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;

  // codes 1..5 give 4..64 passes, everything else one pass
  function automatic logic [RPT_W-1:0] rpt_count(input logic [SEL_W-1:0] sel);
    logic [RPT_W-1:0] n;
    if (sel >= 3'd1 && sel <= 3'd5) n = RPT_W'(1) << (sel + 3'd1);
    else                            n = RPT_W'(1);
    return n;
  endfunction
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/adc_conv_unit.sv
module adc_conv_unit #(
  parameter int DW  = 10,
  parameter int LAT = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] sample,
  output logic          done,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(LAT);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dat_q;
  logic          dat_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    dat_en = 1'b0;
    if (go) begin
      act_d  = 1'b1;
      cnt_d  = CW'(LAT - 1);
      dat_en = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      dat_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      if (dat_en) dat_q <= sample;
    end
  end

  assign done = act_q && (cnt_q == '0);
  assign data = dat_q;

  AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q); // R2
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PW   = 8,
  parameter int TW   = 4,
  parameter int XTRA = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             burst_en,
  input  logic             stay_on,
  input  logic             extra_track,
  input  logic [PW-1:0]    pwr_time,
  input  logic [TW-1:0]    trk_time,
  input  logic [SEL_W-1:0] rpt_sel,
  input  logic             conv_done,
  output logic             conv_go,
  output logic             acc_clr,
  output logic             acc_add,
  output logic             acc_fin,
  output logic             pwr_on,
  output logic             busy,
  output logic             ovr_set
);
  localparam int TMW = (PW > TW + 2) ? PW : TW + 2;

  seq_state_e       state_q, state_d;
  logic [TMW-1:0]   tmr_q, tmr_d;
  logic [RPT_W-1:0] cnt_q, cnt_d;
  logic [RPT_W-1:0] tgt_q;
  logic             burst_q;
  logic             pwr_q, pwr_d;
  logic             cfg_en;
  logic [TMW-1:0]   trk_load;
  logic [TMW-1:0]   pwr_load;
  logic [RPT_W-1:0] cnt_inc;

  assign trk_load = TMW'(trk_time) + (extra_track ? TMW'(XTRA) : '0);
  assign pwr_load = TMW'(pwr_time);
  assign cnt_inc  = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    cnt_d   = cnt_q;
    pwr_d   = pwr_q;
    cfg_en  = 1'b0;
    conv_go = 1'b0;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    acc_fin = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pwr_d = 1'b1;
          if (cnt_q == '0) begin
            cfg_en  = 1'b1;
            acc_clr = 1'b1;
          end
          if (pwr_q) begin
            state_d = ST_TRACK;
            tmr_d   = trk_load;
          end else begin
            state_d = ST_PWRUP;
            tmr_d   = pwr_load;
          end
        end
      end
      ST_PWRUP: begin
        if (tmr_q == '0) begin
          state_d = ST_TRACK;
          tmr_d   = trk_load;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_TRACK: begin
        if (tmr_q == '0) begin
          state_d = ST_CONV;
          conv_go = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          acc_add = 1'b1;
          if (cnt_inc == tgt_q) begin
            acc_fin = 1'b1;
            cnt_d   = '0;
            state_d = ST_IDLE;
            pwr_d   = stay_on;
          end else begin
            cnt_d = cnt_inc;
            if (burst_q) begin
              state_d = ST_TRACK;
              tmr_d   = trk_load;
            end else begin
              state_d = ST_IDLE;
              pwr_d   = stay_on;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
      tgt_q   <= RPT_W'(1);
      burst_q <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      cnt_q   <= cnt_d;
      pwr_q   <= pwr_d;
      if (cfg_en) begin
        tgt_q   <= rpt_count(rpt_sel);
        burst_q <= burst_en;
      end
    end
  end

  assign pwr_on  = pwr_q;
  assign busy    = (state_q != ST_IDLE);
  assign ovr_set = start && (state_q != ST_IDLE);

  AST_WAKE_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && !pwr_q) |=> (state_q == ST_PWRUP)); // R5
  AST_SKIP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && pwr_q) |=> (state_q == ST_TRACK)); // R5
  AST_DONE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (state_q == ST_CONV)); // R2
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && start && !conv_done) |=> (state_q == ST_CONV)); // R8
endmodule

// File: rtl/adc_accum_win.sv
module adc_accum_win #(
  parameter int DW = 10,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic          fin,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          ovr_set,
  input  logic          flag_clr,
  output logic [AW-1:0] result,
  output logic          eoc_flag,
  output logic          win_hit,
  output logic          overrun
);
  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] res_q;
  logic [AW-1:0] sum_w;
  logic          in_win;
  logic          eoc_q, eoc_d;
  logic          win_q, win_d;
  logic          ovr_q, ovr_d;
  logic          acc_en;

  assign sum_w  = acc_q + AW'(data);
  assign in_win = (sum_w >= win_lo) && (sum_w <= win_hi);

  always_comb begin
    acc_en = clr || add;
    acc_d  = clr ? '0 : sum_w;
    eoc_d  = (flag_clr ? 1'b0 : eoc_q) | fin;
    win_d  = (flag_clr ? 1'b0 : win_q) | (fin & in_win);
    ovr_d  = (flag_clr ? 1'b0 : ovr_q) | ovr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      eoc_q <= 1'b0;
      win_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (fin)    res_q <= sum_w;
      eoc_q <= eoc_d;
      win_q <= win_d;
      ovr_q <= ovr_d;
    end
  end

  assign result   = res_q;
  assign eoc_flag = eoc_q;
  assign win_hit  = win_q;
  assign overrun  = ovr_q;

  AST_EOC_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_q) |-> $past(fin)); // R2
  AST_WIN_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> eoc_q); // R7
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fin && !ovr_set) |=> (!eoc_q && !win_q && !ovr_q)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(res_q)); // R9
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int DW   = 10,
  parameter int AW   = 16,
  parameter int PW   = 8,
  parameter int TW   = 4,
  parameter int XTRA = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             burst_en,
  input  logic             stay_on,
  input  logic             extra_track,
  input  logic [PW-1:0]    pwr_time,
  input  logic [TW-1:0]    trk_time,
  input  logic [SEL_W-1:0] rpt_sel,
  input  logic [DW-1:0]    sample_in,
  input  logic [AW-1:0]    win_lo,
  input  logic [AW-1:0]    win_hi,
  input  logic             flag_clr,
  output logic [AW-1:0]    result,
  output logic             eoc_flag,
  output logic             win_hit,
  output logic             overrun,
  output logic             conv_on,
  output logic             busy
);
  localparam int CONV_LAT = DW + 1;

  logic          rst_s_n;
  logic          conv_go, conv_done;
  logic [DW-1:0] conv_data;
  logic          acc_clr, acc_add, acc_fin;
  logic          ovr_set;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  adc_seq_ctrl #(.PW(PW), .TW(TW), .XTRA(XTRA)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .burst_en    (burst_en),
    .stay_on     (stay_on),
    .extra_track (extra_track),
    .pwr_time    (pwr_time),
    .trk_time    (trk_time),
    .rpt_sel     (rpt_sel),
    .conv_done   (conv_done),
    .conv_go     (conv_go),
    .acc_clr     (acc_clr),
    .acc_add     (acc_add),
    .acc_fin     (acc_fin),
    .pwr_on      (conv_on),
    .busy        (busy),
    .ovr_set     (ovr_set)
  );

  adc_conv_unit #(.DW(DW), .LAT(CONV_LAT)) u_conv (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .go     (conv_go),
    .sample (sample_in),
    .done   (conv_done),
    .data   (conv_data)
  );

  adc_accum_win #(.DW(DW), .AW(AW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (acc_clr),
    .add      (acc_add),
    .fin      (acc_fin),
    .data     (conv_data),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .ovr_set  (ovr_set),
    .flag_clr (flag_clr),
    .result   (result),
    .eoc_flag (eoc_flag),
    .win_hit  (win_hit),
    .overrun  (overrun)
  );

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && start) |=> overrun); // R8
  AST_EOC_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(eoc_flag) |-> !busy); // R3
endmodule

// File: tb/sim_adc_burst_seq.sv
module sim_adc_burst_seq;
  localparam int PWR = 5;
  localparam int TRK = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, burst_en, stay_on, extra_track, flag_clr;
  logic [7:0]  pwr_time;
  logic [3:0]  trk_time;
  logic [2:0]  rpt_sel;
  logic [9:0]  sample_in;
  logic [15:0] win_lo, win_hi;
  logic [15:0] result;
  logic        eoc_flag, win_hit, overrun, conv_on, busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int s_edge = 0;
  bit pw_model = 1'b0;
  bit eoc_prev = 1'b0;

  typedef struct {
    int    res;
    bit    hit;
    int    due;
    string req;
  } exp_t;
  exp_t sb[$];

  adc_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_en(burst_en),
    .stay_on(stay_on), .extra_track(extra_track), .pwr_time(pwr_time),
    .trk_time(trk_time), .rpt_sel(rpt_sel), .sample_in(sample_in),
    .win_lo(win_lo), .win_hi(win_hi), .flag_clr(flag_clr),
    .result(result), .eoc_flag(eoc_flag), .win_hit(win_hit),
    .overrun(overrun), .conv_on(conv_on), .busy(busy)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int passes(input logic [2:0] sel);
    if (sel >= 3'd1 && sel <= 3'd5) return 2 ** (sel + 1);
    return 1;
  endfunction

  function automatic int lat(input bit on, input int n, input bit x);
    return (on ? 0 : PWR + 1) + n * (TRK + (x ? 3 : 0) + 1 + 11);
  endfunction

  // monitor: pops an expected item at each rising end-of-conversion
  always @(negedge clk) begin
    if (rst_n && eoc_flag && !eoc_prev) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected eoc", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(result) == e.res, {e.req, " result"}, int'(result), e.res);
        chk(win_hit == e.hit, {e.req, " win_hit R7"}, int'(win_hit), int'(e.hit));
        chk(cyc == e.due, {e.req, " latency R4"}, cyc, e.due);
      end
    end
    eoc_prev = eoc_flag;
  end

  task automatic pulse_start();
    @(negedge clk);
    start  = 1'b1;
    s_edge = cyc + 1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_eoc();
    while (!eoc_flag) @(negedge clk);
  endtask

  task automatic clear_flags(input string req);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(!eoc_flag && !win_hit && !overrun, {req, " flags cleared R9"},
        int'({eoc_flag, win_hit, overrun}), 0);
  endtask

  task automatic run_burst(input logic [2:0] sel, input int s, input bit stay,
                           input bit x, input int lo, input int hi, input string req);
    int  n, sum, k;
    bit  hit;
    exp_t e;
    n   = passes(sel);
    sum = n * s;
    hit = (sum >= lo) && (sum <= hi);
    k   = lat(pw_model, n, x);
    @(negedge clk);
    burst_en = 1'b1; rpt_sel = sel; sample_in = 10'(s); stay_on = stay;
    extra_track = x; win_lo = 16'(lo); win_hi = 16'(hi);
    pulse_start();
    e.res = sum; e.hit = hit; e.due = s_edge + k; e.req = req;
    sb.push_back(e);
    wait_eoc();
    pw_model = stay;
    chk(conv_on == stay, {req, " idle power R5"}, int'(conv_on), int'(stay));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; burst_en = 1'b0; stay_on = 1'b0;
    extra_track = 1'b0; flag_clr = 1'b0; pwr_time = 8'(PWR);
    trk_time = 4'(TRK); rpt_sel = 3'd0; sample_in = '0;
    win_lo = '0; win_hi = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(result == 16'd0, "R1 result", int'(result), 0);
    chk(!eoc_flag && !win_hit && !overrun, "R1 flags",
        int'({eoc_flag, win_hit, overrun}), 0);
    chk(!conv_on && !busy, "R1 power/busy", int'({conv_on, busy}), 0);

    // R2 burst of 4 from power-down, inside window
    run_burst(3'd1, 100, 1'b0, 1'b0, 300, 500, "R2 burst4");
    clear_flags("R2");
    chk(result == 16'd400, "R9 result held", int'(result), 400);

    // R2 R6 R10 full scale 64 passes, extra tracking, stay powered, outside window
    run_burst(3'd5, 1023, 1'b1, 1'b1, 0, 10, "R6 burst64");
    clear_flags("R6");

    // R5 powered start skips the power-up wait, one pass
    run_burst(3'd0, 7, 1'b1, 1'b0, 7, 7, "R5 single on");
    clear_flags("R5");

    // R7 partial sum inside window, final outside: no hit; ends powered down
    run_burst(3'd1, 100, 1'b0, 1'b0, 100, 150, "R7 partial");
    clear_flags("R7");

    // R11 unused code gives one pass
    run_burst(3'd7, 321, 1'b0, 1'b0, 300, 400, "R11 code7");
    clear_flags("R11");

    // R3 single mode: four starts, samples 10,20,30,40
    begin
      exp_t e;
      @(negedge clk);
      burst_en = 1'b0; rpt_sel = 3'd1; stay_on = 1'b0; extra_track = 1'b0;
      win_lo = 16'd50; win_hi = 16'd150;
      for (int i = 0; i < 4; i++) begin
        int k;
        k = lat(pw_model, 1, 1'b0);
        sample_in = 10'(10 * (i + 1));
        pulse_start();
        if (i == 3) begin
          e.res = 100; e.hit = 1'b1; e.due = s_edge + k; e.req = "R3 single";
          sb.push_back(e);
        end
        while (busy) @(negedge clk);
        pw_model = 1'b0;
        if (i < 3) chk(!eoc_flag, "R3 no eoc before count", int'(eoc_flag), 0);
        repeat (3) @(negedge clk);
      end
      wait_eoc();
      clear_flags("R3");
    end

    // R8 overrun: extra start mid-burst is ignored
    begin
      exp_t e;
      int k;
      @(negedge clk);
      burst_en = 1'b1; rpt_sel = 3'd2; sample_in = 10'd50; stay_on = 1'b0;
      win_lo = 16'd0; win_hi = 16'hFFFF;
      k = lat(pw_model, 8, 1'b0);
      pulse_start();
      e.res = 400; e.hit = 1'b1; e.due = s_edge + k; e.req = "R8 overrun";
      sb.push_back(e);
      repeat (20) @(negedge clk);
      sample_in = 10'd50;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(overrun, "R8 overrun set", int'(overrun), 1);
      chk(busy, "R8 still busy", int'(busy), 1);
      wait_eoc();
      pw_model = 1'b0;
      repeat (2) @(negedge clk);
      chk(!busy, "R8 no extra run", int'(busy), 0);
      chk(overrun, "R8 overrun sticky", int'(overrun), 1);
      clear_flags("R8");
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 all results seen", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule